// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a watchdog that counts pulses of a slow, free-running tick. The tick is given as a one-cycle enable on `clk`, and `clk` is taken to be the watchdog's own clock. Because of this the watchdog keeps counting while the processor's main clock is stopped for sleep. Software can route an optional power-of-two prescaler in front of the counter to stretch the period. A static configuration input switches the whole watchdog off. When the count expires, the block sends a one-cycle device-reset request if the system is awake, or a one-cycle wake-up request if it is asleep. In both cases it drives the active-low time-out flag to 0.

Software keeps the watchdog from expiring by strobing `clr_cmd`. The `sleep_cmd` strobe marks entry into sleep and also restarts the count. A small controller with three states follows whether the system is awake:

- `WD_OFF`: the configuration input is low.
- `WD_AWAKE`: normal running.
- `WD_ASLEEP`: entered on `sleep_cmd`.

The transitions are:

- OFF to AWAKE when `cfg_en` rises.
- AWAKE to ASLEEP on `sleep_cmd`.
- ASLEEP to AWAKE on an expiry, which is the wake-up.
- Any state to AWAKE (or to OFF, if `cfg_en` is low) on `warm_rst`.
- Any state to OFF while `cfg_en` is low.

Top module: `wdog_timer`

## Requirements
- R1: While `por_n` is low and in the first cycle after it, `to_n` is 1 and both `reset_req` and `wake_req` are 0.
- R2: With the prescaler not assigned (`assign_wdt`=0), the T-th tick after a restart makes `reset_req` high for the clock cycle after that tick's edge, and `to_n` reads 0 in that same cycle. T is `TIMEOUT_TICKS`.
- R3: Each request pulse lasts exactly one cycle, and the count starts again from zero, so the next expiry needs another full period of ticks.
- R4: With `assign_wdt`=1, the 3-bit `ratio_sel` value n sets a division of 2^n, so the expiry comes on tick T·2^n (1:1 to 1:128).
- R5: With `assign_wdt`=0, `ratio_sel` has no effect and the expiry comes on tick T.
- R6: `clr_cmd` restarts the count, restarts the prescaler when it is assigned, and sets `to_n` to 1.
- R7: `sleep_cmd` restarts the count and the assigned prescaler and moves to sleep. An expiry during sleep pulses `wake_req` and not `reset_req`, and the block is then awake again, so the next expiry pulses `reset_req`.
- R8: While `cfg_en` is 0, no request is ever raised, whatever the ticks.
- R9: `to_n` is unchanged by `sleep_cmd` and by `warm_rst`. `warm_rst` restarts the count and returns the block to awake.
- R10: Cycles without `tick` do not advance the count.
- R11: A `clr_cmd` in the same cycle as the tick that would expire the count wins: no request is raised and the count starts again from zero.
- R12: `reset_req` and `wake_req` are never high together, and each is high only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog-domain clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous non-power-on reset; does not touch `to_n` |
| tick | input | 1 | One-cycle enable from the free-running slow oscillator |
| cfg_en | input | 1 | Configuration enable; 0 disables the watchdog |
| assign_wdt | input | 1 | 1 routes the prescaler to the watchdog; 0 gives 1:1 |
| ratio_sel | input | 3 | Prescaler exponent n, division 2^n |
| clr_cmd | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep-entry strobe |
| reset_req | output | 1 | One-cycle device-reset request (expiry while awake) |
| wake_req | output | 1 | One-cycle wake-up request (expiry while asleep) |
| to_n | output | 1 | Time-out status, active low |

## Verification
The bound checker watches every cycle for the following:

- A request never lasts more than one cycle.
- The two requests never appear together.
- Every request follows a tick and a falling `to_n`.
- Nothing is raised right after `cfg_en` is low or a clear.
- `to_n` rises only after a clear.

The expiry position under each prescaler ratio, the restart of the prescaler by a clear, the hand-over from the sleep state to the awake state, and the effect of a warm reset and of tickless gaps depend on counting long stretches of ticks. Only the directed scenarios can show these.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_AWAKE  = 2'd1,
        WD_ASLEEP = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_STAGES = 7,
    localparam int SEL_W = $clog2(PRE_STAGES + 1)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run,
    input  logic             clear,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    output logic             carry
);

    logic [PRE_STAGES-1:0] pcnt;
    logic [PRE_STAGES-1:0] mask;

    // terminal value is 2^sel - 1; >= guards against a ratio shrinking mid-count
    always_comb begin
        mask  = ~({PRE_STAGES{1'b1}} << sel);
        carry = run && (bypass || (pcnt >= mask));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pcnt <= '0;
        end else if (clear) begin
            pcnt <= '0;
        end else if (run && !bypass) begin
            if (carry) pcnt <= '0;
            else       pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int TIMEOUT_TICKS = 4096,
    localparam int CW = $clog2(TIMEOUT_TICKS)
) (
    input  logic clk,
    input  logic por_n,
    input  logic step,
    input  logic clear,
    output logic expire
);

    logic [CW-1:0] cnt;
    logic          at_top;

    assign at_top = (cnt == CW'(TIMEOUT_TICKS - 1));
    assign expire = step && at_top && !clear;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (clear || expire) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      warm_rst,
    input  logic      cfg_en,
    input  logic      sleep_cmd,
    input  logic      clr_cmd,
    input  logic      expire,
    output wd_state_e state,
    output logic      reset_req,
    output logic      wake_req,
    output logic      to_n
);

    wd_state_e nxt;

    always_comb begin
        nxt = state;
        if (warm_rst) begin
            nxt = cfg_en ? WD_AWAKE : WD_OFF;
        end else if (!cfg_en) begin
            nxt = WD_OFF;
        end else begin
            unique case (state)
                WD_OFF:    nxt = WD_AWAKE;
                WD_AWAKE:  if (sleep_cmd) nxt = WD_ASLEEP;
                WD_ASLEEP: if (expire)    nxt = WD_AWAKE;
                default:   nxt = WD_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= WD_AWAKE;
        else        state <= nxt;
    end

    // outputs: request pulses and the sticky status flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            reset_req <= 1'b0;
            wake_req  <= 1'b0;
            to_n      <= 1'b1;
        end else begin
            reset_req <= expire && (state == WD_AWAKE);
            wake_req  <= expire && (state == WD_ASLEEP);
            if (clr_cmd)     to_n <= 1'b1;
            else if (expire) to_n <= 1'b0;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 4096,
    parameter int PRE_STAGES    = 7,
    localparam int SEL_W = $clog2(PRE_STAGES + 1)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst,
    input  logic             tick,
    input  logic             cfg_en,
    input  logic             assign_wdt,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             clr_cmd,
    input  logic             sleep_cmd,
    output logic             reset_req,
    output logic             wake_req,
    output logic             to_n
);

    wd_state_e state;
    logic      run;
    logic      carry;
    logic      expire;
    logic      cnt_clr;
    logic      pre_clr;

    assign run     = tick && cfg_en && (state != WD_OFF);
    assign cnt_clr = clr_cmd || sleep_cmd || warm_rst || !cfg_en;
    assign pre_clr = ((clr_cmd || sleep_cmd) && assign_wdt) || warm_rst || !cfg_en;

    wdog_prescaler #(.PRE_STAGES(PRE_STAGES)) u_pre (
        .clk    (clk),
        .por_n  (por_n),
        .run    (run),
        .clear  (pre_clr),
        .bypass (!assign_wdt),
        .sel    (ratio_sel),
        .carry  (carry)
    );

    wdog_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
        .clk    (clk),
        .por_n  (por_n),
        .step   (carry),
        .clear  (cnt_clr),
        .expire (expire)
    );

    wdog_ctrl u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .warm_rst  (warm_rst),
        .cfg_en    (cfg_en),
        .sleep_cmd (sleep_cmd),
        .clr_cmd   (clr_cmd),
        .expire    (expire),
        .state     (state),
        .reset_req (reset_req),
        .wake_req  (wake_req),
        .to_n      (to_n)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic clk,
    input logic por_n,
    input logic tick,
    input logic cfg_en,
    input logic clr_cmd,
    input logic reset_req,
    input logic wake_req,
    input logic to_n
);

    // R3
    reset_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        reset_req |=> !reset_req);

    // R3
    wake_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        wake_req |=> !wake_req);

    // R12
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(reset_req && wake_req));

    // R12
    req_after_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
        (reset_req || wake_req) |-> $past(tick));

    // R2
    flag_low_on_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        (reset_req || wake_req) |-> !to_n);

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(cfg_en) |-> !(reset_req || wake_req));

    // R11
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        $past(clr_cmd) |-> !(reset_req || wake_req));

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(to_n) |-> $past(clr_cmd));

endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .tick      (tick),
    .cfg_en    (cfg_en),
    .clr_cmd   (clr_cmd),
    .reset_req (reset_req),
    .wake_req  (wake_req),
    .to_n      (to_n)
);

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;

    localparam int CLK_NS = 10;
    localparam int T      = 5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_rst = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_en = 1'b1;
    logic       assign_wdt = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       clr_cmd = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       reset_req;
    logic       wake_req;
    logic       to_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    wdog_timer #(.TIMEOUT_TICKS(T), .PRE_STAGES(7)) u0 (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst   (warm_rst),
        .tick       (tick),
        .cfg_en     (cfg_en),
        .assign_wdt (assign_wdt),
        .ratio_sel  (ratio_sel),
        .clr_cmd    (clr_cmd),
        .sleep_cmd  (sleep_cmd),
        .reset_req  (reset_req),
        .wake_req   (wake_req),
        .to_n       (to_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // n ticks, one idle cycle between; records first tick index of each request
    task automatic run_ticks(input int n, output int rst_at, output int wake_at,
                             output int pulses);
        rst_at = 0; wake_at = 0; pulses = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            if (reset_req) begin pulses++; if (rst_at == 0) rst_at = i; end
            if (wake_req)  begin pulses++; if (wake_at == 0) wake_at = i; end
        end
    endtask

    // 0: clear, 1: sleep, 2: warm reset
    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: clr_cmd = 1'b1;
            1: sleep_cmd = 1'b1;
            default: warm_rst = 1'b1;
        endcase
        @(negedge clk);
        clr_cmd = 1'b0; sleep_cmd = 1'b0; warm_rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 to_n in reset", to_n, 1);
        chk("R1 reset_req in reset", reset_req, 0);
        @(negedge clk) por_n = 1'b1;
        @(negedge clk);
        chk("R1 to_n after reset", to_n, 1);
        chk("R1 wake_req after reset", wake_req, 0);
    endtask

    task automatic t_plain();
        int r, w, p;
        assign_wdt = 1'b0; ratio_sel = 3'd3;
        strobe(0);
        run_ticks(T, r, w, p);
        chk("R2 R5 expiry tick", r, T);
        chk("R2 to_n after expiry", to_n, 0);
        @(negedge clk);
        chk("R3 pulse one cycle", reset_req, 0);
        run_ticks(T, r, w, p);
        chk("R3 restart period", r, T);
        chk("R3 single pulse per period", p, 1);
    endtask

    task automatic t_prescale();
        int r, w, p;
        assign_wdt = 1'b1; ratio_sel = 3'd2;
        strobe(0);
        chk("R6 clear sets to_n", to_n, 1);
        run_ticks(T * 4, r, w, p);
        chk("R4 ratio 1:4", r, T * 4);
        ratio_sel = 3'd7;
        strobe(0);
        run_ticks(T * 128, r, w, p);
        chk("R4 ratio 1:128", r, T * 128);
        chk("R4 one pulse at 1:128", p, 1);
    endtask

    task automatic t_clear();
        int r, w, p;
        assign_wdt = 1'b1; ratio_sel = 3'd1;
        strobe(0);
        run_ticks(7, r, w, p);
        chk("R6 no early expiry", p, 0);
        strobe(0);
        run_ticks(T * 2, r, w, p);
        chk("R6 clear restarts counter and prescaler", r, T * 2);
    endtask

    task automatic t_sleep();
        int r, w, p;
        assign_wdt = 1'b0;
        strobe(0);
        run_ticks(3, r, w, p);
        strobe(1);
        chk("R9 sleep keeps to_n", to_n, 1);
        run_ticks(T, r, w, p);
        chk("R7 wake in sleep", w, T);
        chk("R7 no reset in sleep", r, 0);
        chk("R7 to_n after wake", to_n, 0);
        run_ticks(T, r, w, p);
        chk("R7 awake again gives reset", r, T);
        chk("R7 no second wake", w, 0);
    endtask

    task automatic t_warm();
        int r, w, p;
        assign_wdt = 1'b0;
        run_ticks(2, r, w, p);
        strobe(2);
        chk("R9 warm reset keeps to_n", to_n, 0);
        run_ticks(T, r, w, p);
        chk("R9 warm reset restarts count", r, T);
        strobe(1);
        run_ticks(2, r, w, p);
        strobe(2);
        run_ticks(T, r, w, p);
        chk("R9 warm reset leaves sleep", r, T);
        chk("R9 no wake after warm reset", w, 0);
    endtask

    task automatic t_disable();
        int r, w, p;
        @(negedge clk) cfg_en = 1'b0;
        run_ticks(T * 4, r, w, p);
        chk("R8 disabled never expires", p, 0);
        @(negedge clk) cfg_en = 1'b1;
        @(negedge clk);
        run_ticks(T, r, w, p);
        chk("R8 re-enabled expires", r, T);
    endtask

    task automatic t_notick();
        int r, w, p;
        strobe(0);
        run_ticks(3, r, w, p);
        repeat (30) @(negedge clk);
        chk("R10 idle gap no request", reset_req, 0);
        run_ticks(2, r, w, p);
        chk("R10 only ticks count", r, 2);
    endtask

    task automatic t_race();
        int r, w, p;
        assign_wdt = 1'b0;
        strobe(0);
        run_ticks(T - 1, r, w, p);
        @(negedge clk) begin tick = 1'b1; clr_cmd = 1'b1; end
        @(negedge clk) begin tick = 1'b0; clr_cmd = 1'b0; end
        chk("R11 clear beats expiry", reset_req, 0);
        run_ticks(T, r, w, p);
        chk("R11 count restarted", r, T);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_plain();
        t_prescale();
        t_clear();
        t_sleep();
        t_warm();
        t_disable();
        t_notick();
        t_race();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule